// File: doc/BRIEF.md
# Write Strobe Protection Filter

This block stands between the raw active-low chip-enable, write-enable and output-enable pins of a memory and its command decoder. It keeps stray or unsafe bus activity from being taken as a write. Every raw input first passes through a two-stage synchronizer. A write pulse is the time during which chip-enable and write-enable are both low while output-enable is high. That pulse counts only if it lasts at least a set number of clock cycles. No write is accepted while the supply-good input is low, or during a holdoff window that starts when supply-good rises.

The address is taken when the two enables first overlap, which is the later of their two falling edges. The data is the value present just before the earlier of their two rising edges. When a write qualifies, the block gives the decoder one single-cycle strobe together with the captured address and data. The holdoff length and the filter width are parameters given in clock cycles.

Top module: `wr_strobe_guard`

## Requirements
- R1: While the synchronized supply-good input is low, or if it falls at any time during a write pulse, that pulse produces no strobe.
- R2: After supply-good rises, a write pulse that overlaps any part of the first HOLD_CYC synchronized cycles produces no strobe. A pulse that starts and ends after that window does produce one.
- R3: If output-enable is low during any cycle of a pulse, including the cycle in which the pulse ends, no strobe is produced. With chip-enable or write-enable held high on its own, no strobe is produced.
- R4: A pulse whose synchronized joint-low time is shorter than FILT_CYC cycles is rejected. This holds whether write-enable or chip-enable is the short one. A pulse of FILT_CYC cycles or more is accepted.
- R5: wr_addr reports the address sampled in the first cycle in which both enables are low. Address changes later in the pulse have no effect.
- R6: wr_data reports the data sampled in the last cycle before either enable returns high. Data changes after that rising edge have no effect.
- R7: Each qualified write gives exactly one wr_valid pulse, one cycle wide. The pulse never appears while the write is still in progress, however long the write is held.
- R8: wr_valid is high in the third clock cycle after the raw enable rises. That is two synchronizer stages plus one output register.
- R9: After reset, wr_valid is low, and writes stay inhibited until supply-good has been high for the holdoff time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Raw chip enable, active low |
| we_n | input | 1 | Raw write enable, active low |
| oe_n | input | 1 | Raw output enable, active low |
| pwr_good | input | 1 | Digital supply-good indication |
| addr | input | AW | Raw address bus |
| data | input | DW | Raw data bus |
| wr_valid | output | 1 | One-cycle strobe for a qualified write |
| wr_addr | output | AW | Address captured for the last qualified write |
| wr_data | output | DW | Data captured for the last qualified write |

## Verification
The bench probes both sides of the filter threshold, with one cycle below it and exactly at it. A design with an off-by-one comparison would reject the boundary pulse or pass the short one. Skewed enable tests move the address after the joint fall and the data after the first rise. A design that latched on the wrong edge would report the moved values. Further tests drop output-enable or supply-good in the middle of a pulse, and place a pulse inside the holdoff window. A design that checked these only at the start or the end of a pulse would emit a strobe it should not. A long pulse and an exact-latency probe catch designs that strobe more than once or strobe in the wrong cycle.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    // Synchronized control inputs; enables are active low
    typedef struct packed {
        logic pwr;
        logic oe_n;
        logic ce_n;
        logic we_n;
    } ctl_t;

    localparam int CTL_W = 4;

    // Reset image: supply low, all enables released
    localparam ctl_t CTL_RST = '{pwr: 1'b0, oe_n: 1'b1, ce_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/wsg_sync.sv
module wsg_sync #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            r_q <= r_d;
        end
    end

    assign q = r_q.s2;

endmodule

// File: rtl/wsg_holdoff.sv
module wsg_holdoff #(
    parameter int HOLD_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_s,
    output logic write_ok
);

    localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HLIM = HW'(HOLD_CYC);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          ready;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!pwr_s) begin
            h_d.cnt   = '0;
            h_d.ready = 1'b0;
        end else begin
            if (h_q.cnt != HLIM) begin
                h_d.cnt = h_q.cnt + 1'b1;
            end
            h_d.ready = (h_q.cnt == HLIM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign write_ok = h_q.ready;

    // supply loss removes write permission on the next cycle
    p_drop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> !write_ok);

    // permission only appears once the full holdoff has been counted
    p_ready_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_ok) |-> ($past(h_q.cnt) == HLIM) && $past(pwr_s));

endmodule

// File: rtl/wsg_filter.sv
module wsg_filter
    import wsg_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 16,
    parameter int FILT_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic          write_ok,
    output logic          strobe,
    output logic [AW-1:0] st_addr,
    output logic [DW-1:0] st_data
);

    localparam int FL = (FILT_CYC < 1) ? 1 : FILT_CYC;
    localparam int CW = $clog2(FL + 1);
    localparam logic [CW-1:0] FLIM = CW'(FL);

    typedef struct packed {
        logic          in_pulse;
        logic [CW-1:0] cnt;
        logic          taint;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          strobe;
        logic [AW-1:0] out_addr;
        logic [DW-1:0] out_data;
    } filt_t;

    filt_t f_d, f_q;
    logic  joint_low;
    logic  ends_now;
    logic  qualified;

    // Both enables low defines the pulse; output-enable is judged separately
    assign joint_low = !ctl.ce_n && !ctl.we_n;
    assign ends_now  = f_q.in_pulse && !joint_low;
    assign qualified = ends_now && !f_q.taint && ctl.oe_n && write_ok
                       && (f_q.cnt >= FLIM);

    always_comb begin
        f_d        = f_q;
        f_d.strobe = 1'b0;
        if (joint_low) begin
            f_d.in_pulse = 1'b1;
            f_d.data     = data_s;
            if (!f_q.in_pulse) begin
                f_d.cnt   = CW'(1);
                f_d.addr  = addr_s;
                f_d.taint = !ctl.oe_n || !write_ok;
            end else begin
                if (f_q.cnt != FLIM) begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
                f_d.taint = f_q.taint || !ctl.oe_n || !write_ok;
            end
        end else begin
            f_d.in_pulse = 1'b0;
            f_d.cnt      = '0;
            f_d.taint    = 1'b0;
            if (qualified) begin
                f_d.strobe   = 1'b1;
                f_d.out_addr = f_q.addr;
                f_d.out_data = f_q.data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign strobe  = f_q.strobe;
    assign st_addr = f_q.out_addr;
    assign st_data = f_q.out_data;

    p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    p_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(f_q.in_pulse) && !$past(joint_low));

    p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($past(f_q.cnt) >= FLIM));

    p_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(ctl.oe_n));

    p_permitted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(write_ok));

endmodule

// File: rtl/wr_strobe_guard.sv
module wr_strobe_guard
    import wsg_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 16,
    parameter int HOLD_CYC = 500000,
    parameter int FILT_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          pwr_good,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam int SW = CTL_W + AW + DW;
    localparam logic [SW-1:0] SRST = {CTL_RST, {(AW + DW){1'b0}}};

    logic [SW-1:0] raw_bus;
    logic [SW-1:0] sync_bus;
    ctl_t          ctl_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          write_ok;

    assign raw_bus = {pwr_good, oe_n, ce_n, we_n, addr, data};

    wsg_sync #(
        .W       (SW),
        .RST_VAL (SRST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    assign ctl_s  = sync_bus[SW-1 -: CTL_W];
    assign addr_s = sync_bus[DW +: AW];
    assign data_s = sync_bus[DW-1:0];

    wsg_holdoff #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_s    (ctl_s.pwr),
        .write_ok (write_ok)
    );

    wsg_filter #(
        .AW       (AW),
        .DW       (DW),
        .FILT_CYC (FILT_CYC)
    ) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl_s),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .write_ok (write_ok),
        .strobe   (wr_valid),
        .st_addr  (wr_addr),
        .st_data  (wr_data)
    );

    // outputs captured for a write stay put until the next qualified write
    p_hold_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> $stable(wr_addr) && $stable(wr_data));

endmodule

// File: tb/sim_wr_strobe_guard.sv
`timescale 1ns/1ps
module sim_wr_strobe_guard;

    localparam int AW   = 17;
    localparam int DW   = 16;
    localparam int HOLD = 20;
    localparam int FILT = 3;
    localparam real CYC = 20.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_good = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    int nstb = 0;
    logic [AW-1:0] got_addr;
    logic [DW-1:0] got_data;

    always #(CYC/2) clk = ~clk;

    wr_strobe_guard #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD), .FILT_CYC(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .pwr_good(pwr_good), .addr(addr), .data(data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

    always @(negedge clk) begin
        if (wr_valid) begin
            nstb     = nstb + 1;
            got_addr = wr_addr;
            got_data = wr_data;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write-enable pulse inside a chip-enable window; counts strobes afterwards
    task automatic we_pulse(input int len, input logic oe_v, input logic [AW-1:0] a,
                            input logic [DW-1:0] d);
        nstb = 0;
        @(negedge clk);
        oe_n = oe_v; addr = a; data = d; ce_n = 1'b0;
        @(negedge clk);
        we_n = 1'b0;
        idle(len);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        idle(8);
    endtask

    localparam int NV = 7;
    localparam int          V_LEN [NV] = '{1, 2, 3, 4, 9, 5, 3};
    localparam logic        V_OE  [NV] = '{1, 1, 1, 1, 1, 0, 1};
    localparam int          V_EXP [NV] = '{0, 0, 1, 1, 1, 0, 1};
    localparam string       V_REQ [NV] = '{"R4", "R4", "R4", "R4", "R7", "R3", "R4"};

    initial begin
        #(CYC * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        check("R9 reset strobe", wr_valid, 0);
        rst_n = 1'b1;
        idle(2);

        // R1: supply low, pulse ignored
        we_pulse(6, 1'b1, 17'h00111, 16'h1111);
        check("R1 supply low", nstb, 0);

        // R2: pulse inside holdoff rejected
        pwr_good = 1'b1;
        idle(3);
        we_pulse(5, 1'b1, 17'h00222, 16'h2222);
        check("R2 in holdoff", nstb, 0);
        idle(HOLD + 10);
        we_pulse(5, 1'b1, 17'h00333, 16'h3333);
        check("R2 after holdoff", nstb, 1);
        check("R9 ready addr", got_addr, 17'h00333);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            we_pulse(V_LEN[i], V_OE[i], AW'(17'h01000 + i), DW'(16'hA000 + i));
            check(V_REQ[i], nstb, V_EXP[i]);
            if (V_EXP[i] != 0) begin
                check({V_REQ[i], " addr"}, got_addr, 17'h01000 + i);
                check({V_REQ[i], " data"}, got_data, 16'hA000 + i);
            end
        end

        // R4: short chip-enable glitch under held write-enable
        nstb = 0;
        we_n = 1'b0;
        idle(2);
        ce_n = 1'b0; idle(2); ce_n = 1'b1;
        idle(2);
        we_n = 1'b1;
        idle(8);
        check("R4 ce glitch", nstb, 0);

        // R5/R6: address at later fall, data before first rise
        nstb = 0;
        addr = 17'h0AAAA; data = 16'h0001; we_n = 1'b0;
        idle(2);
        addr = 17'h15555; ce_n = 1'b0;
        idle(2);
        addr = 17'h00F0F; data = 16'hBEEF;
        idle(2);
        ce_n = 1'b1; data = 16'hDEAD;
        idle(2);
        we_n = 1'b1; data = 16'h5A5A;
        idle(8);
        check("R7 skewed count", nstb, 1);
        check("R5 later fall addr", got_addr, 17'h15555);
        check("R6 first rise data", got_data, 16'hBEEF);

        // R3: output-enable drops mid pulse
        nstb = 0;
        ce_n = 1'b0; we_n = 1'b0; addr = 17'h00042; data = 16'h0042;
        idle(4); oe_n = 1'b0; idle(1); oe_n = 1'b1; idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
        check("R3 oe mid pulse", nstb, 0);

        // R3: write-enable alone without chip-enable
        nstb = 0;
        we_n = 1'b0; idle(6); we_n = 1'b1; idle(8);
        check("R3 we only", nstb, 0);

        // R8: exact latency from raw release
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 17'h00077; data = 16'h7777;
        idle(5);
        we_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R8 not yet", wr_valid, 0);
        @(negedge clk);
        check("R8 strobe", wr_valid, 1);
        check("R8 data", wr_data, 16'h7777);
        @(negedge clk);
        check("R7 one cycle", wr_valid, 0);
        ce_n = 1'b1;
        idle(4);

        // R1: supply drops during a pulse
        nstb = 0;
        ce_n = 1'b0; we_n = 1'b0;
        idle(3); pwr_good = 1'b0; idle(1); pwr_good = 1'b1; idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        idle(8);
        check("R1 drop mid pulse", nstb, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule